// File: doc/BRIEF.md
# Cipher Engine Register Front-End

This block sits between a 32-bit memory-mapped bus and a block-cipher engine. Software loads a key and a 128-bit input block through write-only word registers. It sets the key-valid and operation bits in a control word. When the engine reports completion, software collects the 128-bit output from a read-only window. The engine itself is outside the block. The front-end only stores the operands, drives level-type requests toward the engine, captures the engine's result and tracks completion.

Completion is visible in two ways. The operation bits in the control word clear on their own, which suits polling. If the interrupt enable is set, a level interrupt also rises and stays up until software reads the result window or turns the enable off. The engine keeps expanded round keys for as long as key-valid stays high. To switch keys, software drops key-valid for at least one cycle. While an expansion is in progress, a registered stall flag refuses writes to the key words.

Every output is driven by a register. Writes finish in the cycle they are sampled. Read data appears on the cycle after the read is sampled.

Top module: `cipher_ctl_slave`

## Requirements
- R1: In a cycle where synchronous reset is high, the control word, irq, waitreq and the engine request levels (eng_key_ok, eng_enc, eng_dec) all become zero at the next edge.
- R2: A write to word offset k, with 0 <= k < KEY_WORDS, stores a key word; offset 0 drives the most significant 32 bits of eng_key. A write to a key offset at or above KEY_WORDS (up to 7) has no effect.
- R3: Writes to offsets 8 to 11 store the input block on eng_blk, with offset 8 in bits 127:96 and offset 11 in bits 31:0.
- R4: Offset 31 is the control word and can be both read and written: bit 7 is key-valid (eng_key_ok), bit 6 is interrupt enable, bit 1 requests decryption (eng_dec) and bit 0 requests encryption (eng_enc). Written reserved bits are dropped and always read as zero.
- R5: On an eng_done pulse, eng_result is captured and both operation bits clear at the next edge. The result can be read at offsets 16 to 19, with offset 16 returning bits 127:96. It stays there until the next completion.
- R6: When interrupt enable is set at completion, irq goes high at the edge that samples eng_done and stays high.
- R7: irq goes low at the edge that samples a read of offsets 16 to 19, or at the edge that samples a control write with interrupt enable at zero.
- R8: A completion that happens while interrupt enable is zero leaves irq low.
- R9: After key-valid is set, waitreq is high from the following cycle until eng_key_ready has been seen high. While waitreq is high, writes to key offsets are refused and eng_key stays unchanged.
- R10: While key-valid is low, waitreq is low and key writes are accepted. A key written then is used once key-valid is raised again.
- R11: Reads of key, data and reserved offsets (0 to 15 and 20 to 30) return zero. Read data is valid on the cycle after the read is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 5 | Word offset |
| wdata | input | 32 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| waitreq | output | 1 | Key-write stall flag |
| irq | output | 1 | Completion interrupt level |
| eng_key | output | KEY_WORDS*32 | Key words, offset 0 most significant |
| eng_blk | output | 128 | Input block |
| eng_key_ok | output | 1 | Key-valid level |
| eng_enc | output | 1 | Encrypt request level |
| eng_dec | output | 1 | Decrypt request level |
| eng_key_ready | input | 1 | Engine reports round keys expanded |
| eng_done | input | 1 | One-cycle completion pulse |
| eng_result | input | 128 | Engine output block, valid with eng_done |

## Verification
The assertions assume that wr and rd are never high together. They also assume that software never sets both operation bits in one write, and that eng_done pulses only while an operation bit is set. The bench meets these conditions by issuing every access through single-strobe tasks and by writing only one operation bit per control write. Its engine stub raises eng_done only for a request it has accepted. The stub also latches the key on the rising edge of key-valid, so the key-switch rule can be seen at the result window.

// File: rtl/cc_pkg.sv
package cc_pkg;
    localparam int ADDR_W   = 5;
    localparam int WORD_W   = 32;
    localparam int BLK_W    = 128;
    localparam int BLK_WORDS = BLK_W / WORD_W;

    localparam logic [ADDR_W-1:0] OFS_KEY  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_BLK  = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_RES  = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h1F;

    localparam int BIT_KV  = 7;
    localparam int BIT_IE  = 6;
    localparam int BIT_DEC = 1;
    localparam int BIT_ENC = 0;

    typedef struct packed {
        logic key_ok;
        logic irq_en;
        logic dec;
        logic enc;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.key_ok = w[BIT_KV];
        c.irq_en = w[BIT_IE];
        c.dec    = w[BIT_DEC];
        c.enc    = w[BIT_ENC];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_ctrl(input ctrl_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[BIT_KV]  = c.key_ok;
        w[BIT_IE]  = c.irq_en;
        w[BIT_DEC] = c.dec;
        w[BIT_ENC] = c.enc;
        return w;
    endfunction

    function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                       input logic [ADDR_W-1:0] base,
                                       input int n);
        return (a >= base) && (int'(a) < int'(base) + n);
    endfunction
endpackage

// File: rtl/cc_regs.sv
module cc_regs
    import cc_pkg::*;
#(
    parameter int KEY_WORDS = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [WORD_W-1:0]           wdata,
    input  logic                        stall,
    output logic [KEY_WORDS*WORD_W-1:0] key_o,
    output logic [BLK_W-1:0]            blk_o
);
    localparam int KEY_W = KEY_WORDS * WORD_W;

    for (genvar k = 0; k < KEY_WORDS; k++) begin : g_key
        localparam int HI = KEY_W - 1 - k * WORD_W;
        always_ff @(posedge clk) begin
            if (rst)
                key_o[HI -: WORD_W] <= '0;
            else if (wr && !stall && addr == OFS_KEY + ADDR_W'(k))
                key_o[HI -: WORD_W] <= wdata;
        end
    end

    for (genvar b = 0; b < BLK_WORDS; b++) begin : g_blk
        localparam int HI = BLK_W - 1 - b * WORD_W;
        always_ff @(posedge clk) begin
            if (rst)
                blk_o[HI -: WORD_W] <= '0;
            else if (wr && addr == OFS_BLK + ADDR_W'(b))
                blk_o[HI -: WORD_W] <= wdata;
        end
    end

    // R9
    key_stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && stall && in_window(addr, OFS_KEY, KEY_WORDS)) |=> $stable(key_o));
endmodule

// File: rtl/cc_ctrl.sv
module cc_ctrl
    import cc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              eng_done,
    input  logic              eng_key_ready,
    output ctrl_t             ctrl_q,
    output logic              irq_q,
    output logic              busy_q
);
    ctrl_t ctrl_nxt;
    logic  irq_nxt;
    logic  res_read;

    assign res_read = rd && in_window(addr, OFS_RES, BLK_WORDS);

    always_comb begin
        ctrl_nxt = ctrl_q;
        if (wr && addr == OFS_CTRL)
            ctrl_nxt = unpack_ctrl(wdata);
        if (eng_done) begin
            ctrl_nxt.enc = 1'b0;
            ctrl_nxt.dec = 1'b0;
        end
        irq_nxt = irq_q;
        if (eng_done && ctrl_nxt.irq_en)
            irq_nxt = 1'b1;
        else if (!ctrl_nxt.irq_en || res_read)
            irq_nxt = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            irq_q  <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            ctrl_q <= ctrl_nxt;
            irq_q  <= irq_nxt;
            busy_q <= ctrl_nxt.key_ok && !eng_key_ready;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (ctrl_q == '0) && !irq_q && !busy_q);
    // R5
    done_clears_op_chk: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> !ctrl_q.enc && !ctrl_q.dec);
    // R6
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(eng_done));
    // R7
    irq_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (res_read && !eng_done) |=> !irq_q);
    // R10
    no_stall_unkeyed_chk: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.key_ok |-> !busy_q);
endmodule

// File: rtl/cc_rdport.sv
module cc_rdport
    import cc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  ctrl_t             ctrl,
    input  logic              eng_done,
    input  logic [BLK_W-1:0]  eng_result,
    output logic [WORD_W-1:0] rdata_q
);
    logic [BLK_W-1:0]  res_q;
    logic [WORD_W-1:0] sel;

    always_ff @(posedge clk) begin
        if (rst)
            res_q <= '0;
        else if (eng_done)
            res_q <= eng_result;
    end

    always_comb begin
        sel = '0;
        if (addr == OFS_CTRL)
            sel = pack_ctrl(ctrl);
        else
            for (int i = 0; i < BLK_WORDS; i++)
                if (addr == OFS_RES + ADDR_W'(i))
                    sel = res_q[BLK_W-1-i*WORD_W -: WORD_W];
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (rd)
            rdata_q <= sel;
    end

    // R4
    ctrl_reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == OFS_CTRL) |=> (rdata_q[31:8] == '0) && (rdata_q[5:2] == '0));
    // R11
    wo_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && addr < OFS_RES) |=> rdata_q == '0);
endmodule

// File: rtl/cipher_ctl_slave.sv
module cipher_ctl_slave
    import cc_pkg::*;
#(
    parameter int KEY_WORDS = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [4:0]                  addr,
    input  logic [31:0]                 wdata,
    input  logic                        wr,
    input  logic                        rd,
    output logic [31:0]                 rdata,
    output logic                        waitreq,
    output logic                        irq,
    output logic [KEY_WORDS*32-1:0]     eng_key,
    output logic [127:0]                eng_blk,
    output logic                        eng_key_ok,
    output logic                        eng_enc,
    output logic                        eng_dec,
    input  logic                        eng_key_ready,
    input  logic                        eng_done,
    input  logic [127:0]                eng_result
);
    ctrl_t ctrl;

    cc_regs #(.KEY_WORDS(KEY_WORDS)) u_regs (
        .clk(clk), .rst(rst), .wr(wr), .addr(addr), .wdata(wdata),
        .stall(waitreq), .key_o(eng_key), .blk_o(eng_blk)
    );

    cc_ctrl u_ctrl (
        .clk(clk), .rst(rst), .wr(wr), .rd(rd), .addr(addr), .wdata(wdata),
        .eng_done(eng_done), .eng_key_ready(eng_key_ready),
        .ctrl_q(ctrl), .irq_q(irq), .busy_q(waitreq)
    );

    cc_rdport u_rd (
        .clk(clk), .rst(rst), .rd(rd), .addr(addr), .ctrl(ctrl),
        .eng_done(eng_done), .eng_result(eng_result), .rdata_q(rdata)
    );

    assign eng_key_ok = ctrl.key_ok;
    assign eng_enc    = ctrl.enc;
    assign eng_dec    = ctrl.dec;

    // R8
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_done && !ctrl.irq_en && !(wr && addr == OFS_CTRL)) |=> !irq);
endmodule

// File: tb/cipher_ctl_slave_test.sv
module cipher_ctl_slave_test;
    localparam int KW = 8;
    localparam int EXP_CYC = 12;
    localparam int LAT_CYC = 6;

    logic clk = 0, rst = 1;
    logic [4:0] addr = '0;
    logic [31:0] wdata = '0;
    logic wr = 0, rd = 0;
    logic [31:0] rdata;
    logic waitreq, irq, key_ok, enc, dec;
    logic [KW*32-1:0] key;
    logic [127:0] blk;
    logic key_ready, done;
    logic [127:0] result;

    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    cipher_ctl_slave #(.KEY_WORDS(KW)) uut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
        .rdata(rdata), .waitreq(waitreq), .irq(irq), .eng_key(key), .eng_blk(blk),
        .eng_key_ok(key_ok), .eng_enc(enc), .eng_dec(dec),
        .eng_key_ready(key_ready), .eng_done(done), .eng_result(result)
    );

    function automatic logic [127:0] model(input logic [KW*32-1:0] k,
                                           input logic [127:0] b, input logic d);
        logic [127:0] k2;
        k2 = k[255:128] ^ k[127:0];
        return d ? (b ^ ~k2) : ({b[119:0], b[127:120]} ^ k2);
    endfunction

    // engine stub
    logic kv_d, run, fired, op_d;
    logic [KW*32-1:0] klat;
    int ecnt, lcnt;
    always_ff @(posedge clk) begin
        kv_d <= key_ok;
        done <= 1'b0;
        if (rst || !key_ok) begin
            key_ready <= 1'b0; ecnt <= 0; run <= 1'b0; fired <= 1'b0;
            result <= '0; klat <= '0; op_d <= 1'b0; lcnt <= 0;
        end else begin
            if (!kv_d) begin klat <= key; ecnt <= 1; end
            else if (ecnt != 0) begin
                if (ecnt == EXP_CYC) begin key_ready <= 1'b1; ecnt <= 0; end
                else ecnt <= ecnt + 1;
            end
            if (!(enc || dec)) fired <= 1'b0;
            if (run) begin
                if (lcnt == LAT_CYC) begin
                    done <= 1'b1; result <= model(klat, blk, op_d);
                    run <= 1'b0; fired <= 1'b1;
                end else lcnt <= lcnt + 1;
            end else if ((enc || dec) && key_ready && !fired) begin
                run <= 1'b1; lcnt <= 0; op_d <= dec;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_w(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); wr = 1; addr = a; wdata = d;
        @(negedge clk); wr = 0;
    endtask

    task automatic rd_w(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); rd = 1; addr = a;
        @(negedge clk); rd = 0; d = rdata;
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] c;
        int t = 0;
        do begin rd_w(5'h1F, c); t++; end while ((c[1:0] != 0) && t < 200);
        chk(c[1:0] == 0, req, c, c & 32'hC0);
    endtask

    task automatic load_key(input logic [KW*32-1:0] k);
        for (int i = 0; i < KW; i++) wr_w(5'(i), k[KW*32-1-i*32 -: 32]);
    endtask

    typedef struct packed { logic [127:0] b; logic d; logic ie; } vec_t;
    localparam vec_t VEC [4] = '{
        '{128'h00112233_44556677_8899AABB_CCDDEEFF, 1'b0, 1'b1},
        '{128'h0F0E0D0C_0B0A0908_07060504_03020100, 1'b1, 1'b1},
        '{128'hDEADBEEF_01234567_89ABCDEF_FEEDFACE, 1'b0, 1'b0},
        '{128'h55555555_AAAAAAAA_12121212_34343434, 1'b1, 1'b0}
    };

    localparam logic [255:0] KEY1 = 256'h000102030405060708090A0B0C0D0E0F_101112131415161718191A1B1C1D1E1F;
    localparam logic [255:0] KEY2 = 256'hA5A5A5A5_5A5A5A5A_C3C3C3C3_3C3C3C3C_F0F0F0F0_0F0F0F0F_99999999_66666666;

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(1'b0, "WATCHDOG", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        logic [127:0] got;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!irq && !waitreq && !key_ok && !enc && !dec, "R1", {irq, waitreq, key_ok, enc, dec}, 0);
        @(negedge clk); rst = 0;
        rd_w(5'h1F, r);
        chk(r == 0, "R1 ctrl", r, 0);

        // R2 / R3 loading
        load_key(KEY1);
        chk(key == KEY1, "R2 key order", key, KEY1);
        for (int i = 0; i < 4; i++) wr_w(5'(8 + i), VEC[0].b[127-i*32 -: 32]);
        chk(blk == VEC[0].b, "R3 block order", blk, VEC[0].b);

        // R11 reads of write-only / reserved
        rd_w(5'h00, r); chk(r == 0, "R11 key read", r, 0);
        rd_w(5'h09, r); chk(r == 0, "R11 data read", r, 0);
        rd_w(5'h15, r); chk(r == 0, "R11 reserved read", r, 0);

        // R4 reserved control bits dropped
        wr_w(5'h1F, 32'hFFFF_FF7C);
        rd_w(5'h1F, r); chk(r == 32'h40, "R4 ctrl readback", r, 32'h40);

        // R9 stall after key-valid
        wr_w(5'h1F, 32'h80);
        chk(waitreq == 1'b1, "R9 waitreq high", waitreq, 1);
        wr_w(5'h00, 32'hFFFF_FFFF);
        chk(key == KEY1, "R9 key write refused", key, KEY1);
        begin
            int t = 0;
            while (waitreq && t < 100) begin @(negedge clk); t++; end
        end
        chk(!waitreq && key_ready, "R9 waitreq released", waitreq, 0);

        // vector table
        for (int v = 0; v < 4; v++) begin
            logic [127:0] exp;
            exp = model(KEY1, VEC[v].b, VEC[v].d);
            for (int i = 0; i < 4; i++) wr_w(5'(8 + i), VEC[v].b[127-i*32 -: 32]);
            wr_w(5'h1F, {24'h0, 1'b1, VEC[v].ie, 4'h0, VEC[v].d, !VEC[v].d});
            wait_idle("R5 op bits cleared");
            chk(irq == VEC[v].ie, VEC[v].ie ? "R6 irq raised" : "R8 irq stays low", irq, VEC[v].ie);
            for (int i = 0; i < 4; i++) begin
                rd_w(5'(16 + i), r);
                got[127-i*32 -: 32] = r;
                if (i == 0) chk(!irq, "R7 irq cleared by result read", irq, 0);
            end
            chk(got == exp, "R5 result window", got, exp);
        end

        // R7 clear by disabling enable
        wr_w(5'h1F, 32'hC1);
        wait_idle("R5 op bits cleared");
        chk(irq, "R6 irq held", irq, 1);
        wr_w(5'h1F, 32'h80);
        chk(!irq, "R7 irq cleared by enable off", irq, 0);

        // R10 key switch
        wr_w(5'h1F, 32'h00);
        chk(!waitreq, "R10 no stall while unkeyed", waitreq, 0);
        load_key(KEY2);
        chk(key == KEY2, "R10 key accepted", key, KEY2);
        wr_w(5'h1F, 32'h81);
        wait_idle("R5 op bits cleared");
        for (int i = 0; i < 4; i++) begin
            rd_w(5'(16 + i), r); got[127-i*32 -: 32] = r;
        end
        chk(got == model(KEY2, VEC[3].b, 1'b0), "R10 new key used", got, model(KEY2, VEC[3].b, 1'b0));

        // R1 reset in mid-state
        wr_w(5'h1F, 32'hC0);
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        chk(!key_ok && !irq && !waitreq, "R1 reset clears", {key_ok, irq, waitreq}, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule